// File: doc/BRIEF.md
# Command Ring Packet Processor

This block consumes a stream of 32-bit command words that software places in a circular ring in memory. Software advances a write pointer and pulses `kick`. The block then fetches words at the read pointer until the read pointer catches up with the write pointer. Every packet begins with a header word that gives a packet type, an opcode and a payload count. The block runs the opcodes it knows:

- write a run of shader configuration registers;
- wait on a memory word or on an immediate value;
- write a 64-bit value or a 32-bit timestamp to memory;
- issue a kernel dispatch request.

Cache-maintenance and event packets are read and thrown away.

All memory traffic goes through one request port with a valid/ready handshake, and only one request is outstanding at a time. A read returns on a separate response strobe. The dispatch port presents the grid size together with the program and argument addresses, which are built from the internal register file, and holds them until the consumer accepts. When a wait condition is not met, the read pointer moves back to the start of the wait packet and the block goes idle, so the next kick tries the wait again. A malformed or unsupported packet sets a sticky error flag and stops the block until reset.

Top module: `cmd_ring_proc`

## Requirements
- R1: After reset, `rptr` is 0, `err` is 0, `busy` is 0, and neither `mem_req_valid` nor `disp_valid` is asserted.
- R2: Each command word is fetched by a read at `ring_base + 4*(rptr mod 2^RING_LOG2)`. Each fetched word adds one to `rptr`. A kick starts processing, and at each packet boundary processing stops (`busy` low) once `rptr` is no longer below `wptr`. `rptr` changes only by +1 or by -7.
- R3: Header bits 31:30 must be 3. Bits 15:8 hold the opcode and bits 29:16 the count n. Every packet carries n+1 payload words. The opcodes are 0x76 register write, 0x3C wait, 0x49 release, 0x15 dispatch, 0x58 acquire (skip) and 0x46 event (skip).
- R4: A register-write packet gives a start index (its low IDX_W bits are used, so it wraps modulo NREGS) and then n data words. The data words go to consecutive registers, and the index wraps at NREGS.
- R5: A dispatch packet (n=3) carries grid X, Y and Z and a flags word. The block presents the grid, the program address `{reg[PROG_IDX+1],reg[PROG_IDX]} << 8` and the argument address `{reg[ARGS_IDX+1],reg[ARGS_IDX]}`, and holds them stable until `disp_ready`.
- R6: A release packet (n=6) with select field (word 2, bits 31:29) equal to 1 or 2 issues one 64-bit write (`mem_req_wide`=1). The address is {word4,word3} and the data is {word6,word5}.
- R7: A release with select 3 and event type (word 1, bits 7:0) 0x14 issues a 32-bit write (`mem_req_wide`=0) of a cycle counter that runs from reset. Later timestamps are larger than earlier ones.
- R8: A wait packet (n=5) has info, address low, address high, reference, mask and timeout words. The function is info bits 2:0, where 3 means equal and 5 means greater-or-equal. The space is info bit 4. Space 0 compares the reference with itself. Space 1 reads the 32-bit word at {high,low} and compares it with the reference, without masking.
- R9: When a wait fails, `rptr` moves back by 7 to the wait header. The block goes idle with `err` low, performs no later packet, and on the next kick re-executes the wait.
- R10: Acquire packets (n=6) and event packets (n=0) are consumed with no memory write and no dispatch.
- R11: Any of the following sets `err`, which stays set until reset, and stops all further requests; a kick is then ignored:
  - a non-3 packet type;
  - an unknown opcode;
  - a count that does not match a fixed-size opcode;
  - a wait function other than 3 or 5;
  - a release select/event combination other than those in R6 and R7.
- R12: A memory request holds its address, data and direction stable until `mem_req_ready`. After a read is accepted, no new request is issued until `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick | input | 1 | Start or resume processing |
| ring_base | input | ADDR_W | Byte address of ring word 0 |
| wptr | input | PTR_W | Write pointer in dwords |
| rptr | output | PTR_W | Read pointer in dwords |
| busy | output | 1 | Processing in progress |
| err | output | 1 | Sticky error flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_wide | output | 1 | Write size: 1 = 64 bits, 0 = 32 bits |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 64 | Write data (low 32 bits for narrow writes) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| disp_valid | output | 1 | Dispatch request valid |
| disp_ready | input | 1 | Dispatch request accepted |
| disp_grid_x | output | 32 | Grid size X |
| disp_grid_y | output | 32 | Grid size Y |
| disp_grid_z | output | 32 | Grid size Z |
| disp_prog_addr | output | ADDR_W | Kernel program address |
| disp_args_addr | output | ADDR_W | Kernel argument address |

## Verification
The hardest case to reach is the wait retry. A wait packet must fail against memory contents and leave the pointer rewound, with a later packet already queued behind it that must not run. Memory then has to change before a second kick. The stimulus queues a failing space-1 wait followed by a release, checks `rptr` and that no write appears, then rewrites the polled word and kicks again, expecting the release exactly once. Random back-pressure on both ready inputs keeps request and dispatch fields under hold conditions for several cycles at a time.

// File: rtl/cmdp_pkg.sv
// Shared constants and state type for the command ring packet processor.
// Assumes opcode codes follow the usual type-3 command encoding.
package cmdp_pkg;
    localparam logic [7:0] OP_SET_REGS = 8'h76;
    localparam logic [7:0] OP_ACQUIRE  = 8'h58;
    localparam logic [7:0] OP_RELEASE  = 8'h49;
    localparam logic [7:0] OP_WAIT     = 8'h3C;
    localparam logic [7:0] OP_DISPATCH = 8'h15;
    localparam logic [7:0] OP_EVENT    = 8'h46;

    localparam logic [2:0] FN_EQ  = 3'd3;
    localparam logic [2:0] FN_GEQ = 3'd5;
    localparam logic [7:0] EVT_FLUSH_TS = 8'h14;
    localparam int         WAIT_PKT_DW  = 7;
    localparam int         BUF_WORDS    = 6;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RUN, ST_FREQ, ST_FRSP, ST_EXEC,
        ST_PREQ, ST_PRSP, ST_STORE, ST_DISP, ST_HALT
    } cmdp_state_e;
endpackage

// File: rtl/cmdp_hdr_decode.sv
// Header decoder: checks packet type, opcode and the payload count.
// Assumes the caller passes header bits 31:8; bits 7:0 carry nothing used.
module cmdp_hdr_decode
    import cmdp_pkg::*;
(
    input  logic [31:8] hdr,
    output logic [7:0]  opcode,
    output logic [13:0] count,
    output logic        legal
);
    assign opcode = hdr[15:8];
    assign count  = hdr[29:16];

    // Accept only type 3 with a known opcode and a matching fixed count.
    always_comb begin
        legal = 1'b0;
        if (hdr[31:30] == 2'd3) begin
            case (opcode)
                OP_SET_REGS: legal = 1'b1;
                OP_ACQUIRE:  legal = (count == 14'd6);
                OP_RELEASE:  legal = (count == 14'd6);
                OP_WAIT:     legal = (count == 14'd5);
                OP_DISPATCH: legal = (count == 14'd3);
                OP_EVENT:    legal = (count == 14'd0);
                default:     legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cmdp_wait_cmp.sv
// Wait-condition comparator: equal or greater-or-equal on 32-bit operands.
// Assumes unsigned comparison; other function codes are flagged unsupported.
module cmdp_wait_cmp
    import cmdp_pkg::*;
(
    input  logic [2:0]  func,
    input  logic [31:0] lhs,
    input  logic [31:0] rhs,
    output logic        func_ok,
    output logic        pass
);
    // Evaluate the selected comparison.
    always_comb begin
        func_ok = 1'b1;
        pass    = 1'b0;
        case (func)
            FN_EQ:   pass = (lhs == rhs);
            FN_GEQ:  pass = (lhs >= rhs);
            default: func_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmdp_regfile.sv
// Shader configuration register file: one write port, two fixed 64-bit pair reads.
// Assumes indices wrap modulo NREGS; all registers clear on reset.
module cmdp_regfile #(
    parameter int IDX_W    = 6,
    parameter int PROG_IDX = 12,
    parameter int ARGS_IDX = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    output logic [63:0]      prog_pair,
    output logic [63:0]      args_pair
);
    localparam int NREGS   = 1 << IDX_W;
    localparam int PROG_LO = PROG_IDX % NREGS;
    localparam int PROG_HI = (PROG_IDX + 1) % NREGS;
    localparam int ARGS_LO = ARGS_IDX % NREGS;
    localparam int ARGS_HI = (ARGS_IDX + 1) % NREGS;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [31:0] q;
        // Capture write data when this register is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                q <= '0;
            else if (we && widx == IDX_W'(g))          q <= wdata;
        end
    end

    assign prog_pair = {g_reg[PROG_HI].q, g_reg[PROG_LO].q};
    assign args_pair = {g_reg[ARGS_HI].q, g_reg[ARGS_LO].q};
endmodule

// File: rtl/cmdp_tstamp.sv
// Free-running cycle counter used as the release timestamp source.
// Assumes wrap-around at 2^32 is acceptable.
module cmdp_tstamp (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] count
);
    // Count every cycle since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 32'd1;
    end
endmodule

// File: rtl/cmd_ring_proc.sv
// Command ring packet processor: fetches dwords from a ring at rptr while
// rptr < wptr, decodes type-3 packets and executes register writes, waits,
// release writes and dispatches. Assumes complete packets in the ring and a
// memory that answers each accepted read with exactly one response.
module cmd_ring_proc
    import cmdp_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PTR_W     = 32,
    parameter int RING_LOG2 = 4,
    parameter int IDX_W     = 6,
    parameter int PROG_IDX  = 12,
    parameter int ARGS_IDX  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [PTR_W-1:0]  wptr,
    output logic [PTR_W-1:0]  rptr,
    output logic              busy,
    output logic              err,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic              mem_req_wide,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [63:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [31:0]       disp_grid_x,
    output logic [31:0]       disp_grid_y,
    output logic [31:0]       disp_grid_z,
    output logic [ADDR_W-1:0] disp_prog_addr,
    output logic [ADDR_W-1:0] disp_args_addr
);
    localparam int CNT_W = 15;

    cmdp_state_e       state_q;
    logic [PTR_W-1:0]  rptr_q;
    logic              in_body_q;
    logic [7:0]        op_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  idx_q;
    logic [31:0]       buf_q [BUF_WORDS];
    logic [IDX_W-1:0]  rptr_reg_q;
    logic              err_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [63:0]       wr_data_q;
    logic              wr_wide_q;

    logic [7:0]  hd_op;
    logic [13:0] hd_cnt;
    logic        hd_legal;
    logic        cmp_ok, cmp_pass;
    logic [31:0] cmp_lhs;
    logic        rf_we;
    logic [63:0] prog_pair, args_pair;
    logic [31:0] ts_now;
    logic [2:0]  rel_sel;
    logic        fetch_done;

    cmdp_hdr_decode u_dec (
        .hdr(mem_rsp_data[31:8]), .opcode(hd_op), .count(hd_cnt), .legal(hd_legal)
    );

    assign cmp_lhs = (state_q == ST_PRSP) ? mem_rsp_data : buf_q[3];
    cmdp_wait_cmp u_cmp (
        .func(buf_q[0][2:0]), .lhs(cmp_lhs), .rhs(buf_q[3]),
        .func_ok(cmp_ok), .pass(cmp_pass)
    );

    assign rf_we = (state_q == ST_FRSP) && mem_rsp_valid && in_body_q &&
                   (op_q == OP_SET_REGS) && (idx_q != '0);
    cmdp_regfile #(.IDX_W(IDX_W), .PROG_IDX(PROG_IDX), .ARGS_IDX(ARGS_IDX)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(rptr_reg_q), .wdata(mem_rsp_data),
        .prog_pair(prog_pair), .args_pair(args_pair)
    );

    cmdp_tstamp u_ts (.clk(clk), .rst_n(rst_n), .count(ts_now));

    assign rel_sel    = buf_q[1][31:29];
    assign fetch_done = (left_q == CNT_W'(1));

    // Main sequencer: fetch, decode, execute, rewind or halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rptr_q     <= '0;
            in_body_q  <= 1'b0;
            op_q       <= '0;
            left_q     <= '0;
            idx_q      <= '0;
            rptr_reg_q <= '0;
            err_q      <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
            wr_wide_q  <= 1'b0;
            for (int i = 0; i < BUF_WORDS; i++) buf_q[i] <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (kick) state_q <= ST_RUN;
                ST_RUN:  state_q <= (rptr_q < wptr) ? ST_FREQ : ST_IDLE;
                ST_FREQ: if (mem_req_ready) state_q <= ST_FRSP;
                ST_FRSP: if (mem_rsp_valid) begin
                    rptr_q <= rptr_q + PTR_W'(1);
                    if (!in_body_q) begin
                        if (!hd_legal) begin
                            err_q   <= 1'b1;
                            state_q <= ST_HALT;
                        end else begin
                            op_q      <= hd_op;
                            left_q    <= CNT_W'(hd_cnt) + CNT_W'(1);
                            idx_q     <= '0;
                            in_body_q <= 1'b1;
                            state_q   <= ST_FREQ;
                        end
                    end else begin
                        if (idx_q < CNT_W'(BUF_WORDS)) buf_q[idx_q[2:0]] <= mem_rsp_data;
                        if (op_q == OP_SET_REGS) begin
                            if (idx_q == '0) rptr_reg_q <= mem_rsp_data[IDX_W-1:0];
                            else             rptr_reg_q <= rptr_reg_q + IDX_W'(1);
                        end
                        idx_q  <= idx_q + CNT_W'(1);
                        left_q <= left_q - CNT_W'(1);
                        if (fetch_done) begin
                            in_body_q <= 1'b0;
                            state_q   <= ST_EXEC;
                        end else begin
                            state_q   <= ST_FREQ;
                        end
                    end
                end
                ST_EXEC: begin
                    case (op_q)
                        OP_WAIT: begin
                            if (!cmp_ok) begin
                                err_q   <= 1'b1;
                                state_q <= ST_HALT;
                            end else if (buf_q[0][4]) begin
                                state_q <= ST_PREQ;
                            end else if (cmp_pass) begin
                                state_q <= ST_RUN;
                            end else begin
                                rptr_q  <= rptr_q - PTR_W'(WAIT_PKT_DW);
                                state_q <= ST_IDLE;
                            end
                        end
                        OP_RELEASE: begin
                            wr_addr_q <= ADDR_W'({buf_q[3], buf_q[2]});
                            if (rel_sel == 3'd1 || rel_sel == 3'd2) begin
                                wr_data_q <= {buf_q[5], buf_q[4]};
                                wr_wide_q <= 1'b1;
                                state_q   <= ST_STORE;
                            end else if (rel_sel == 3'd3 && buf_q[0][7:0] == EVT_FLUSH_TS) begin
                                wr_data_q <= {32'd0, ts_now};
                                wr_wide_q <= 1'b0;
                                state_q   <= ST_STORE;
                            end else begin
                                err_q   <= 1'b1;
                                state_q <= ST_HALT;
                            end
                        end
                        OP_DISPATCH: state_q <= ST_DISP;
                        default:     state_q <= ST_RUN;
                    endcase
                end
                ST_PREQ: if (mem_req_ready) state_q <= ST_PRSP;
                ST_PRSP: if (mem_rsp_valid) begin
                    if (cmp_pass) begin
                        state_q <= ST_RUN;
                    end else begin
                        rptr_q  <= rptr_q - PTR_W'(WAIT_PKT_DW);
                        state_q <= ST_IDLE;
                    end
                end
                ST_STORE: if (mem_req_ready) state_q <= ST_RUN;
                ST_DISP:  if (disp_ready)    state_q <= ST_RUN;
                default:  state_q <= ST_HALT;
            endcase
        end
    end

    // Memory request multiplexer across ring fetch, poll read and store.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_wide  = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        case (state_q)
            ST_FREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ring_base + ADDR_W'({rptr_q[RING_LOG2-1:0], 2'b00});
            end
            ST_PREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ADDR_W'({buf_q[2], buf_q[1]});
            end
            ST_STORE: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_wide  = wr_wide_q;
                mem_req_addr  = wr_addr_q;
                mem_req_wdata = wr_data_q;
            end
            default: ;
        endcase
    end

    assign rptr           = rptr_q;
    assign err            = err_q;
    assign busy           = (state_q != ST_IDLE) && (state_q != ST_HALT);
    assign disp_valid     = (state_q == ST_DISP);
    assign disp_grid_x    = buf_q[0];
    assign disp_grid_y    = buf_q[1];
    assign disp_grid_z    = buf_q[2];
    assign disp_prog_addr = ADDR_W'(prog_pair << 8);
    assign disp_args_addr = ADDR_W'(args_pair);

    // R12: request fields hold until accepted.
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
        $stable(mem_req_we) && $stable(mem_req_wdata));

    // R12: after an accepted read, no new request before the response.
    p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready && !mem_req_we |=> !mem_req_valid || $past(mem_rsp_valid));

    // R5: dispatch fields hold until accepted.
    p_disp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_prog_addr) &&
        $stable(disp_args_addr) && $stable(disp_grid_x));

    // R2: rptr moves only forward by one or back by a wait packet.
    p_rptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rptr) |-> (rptr == $past(rptr) + PTR_W'(1)) ||
                           (rptr == $past(rptr) - PTR_W'(WAIT_PKT_DW)));

    // R11: error is sticky and silences the block.
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err && !mem_req_valid && !disp_valid && !busy);
endmodule

// File: tb/tb_cmd_ring_proc.sv
`timescale 1ns/1ps
module tb_cmd_ring_proc;
    localparam int RING   = 16;
    localparam int RB     = 32'h40;
    localparam int POLL_A = 32'h100;

    typedef struct {
        logic [63:0] addr;
        logic [63:0] data;
        logic        wide;
        logic        is_ts;
        string       tag;
    } wr_item_t;
    typedef struct {
        logic [31:0] x, y, z;
        logic [63:0] prog, args;
    } dp_item_t;

    logic        clk = 0, rst_n = 0, kick = 0;
    logic [31:0] wptr = 0;
    logic [31:0] rptr;
    logic        busy, err;
    logic        mem_req_valid, mem_req_ready, mem_req_we, mem_req_wide;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        disp_valid, disp_ready;
    logic [31:0] gx, gy, gz;
    logic [63:0] paddr, aaddr;

    logic [31:0] mem [128];
    wr_item_t    exp_wr[$];
    dp_item_t    exp_dp[$];
    int wi = 0, di = 0, mon_checks = 0, mon_fails = 0;
    int checks = 0, fails = 0, wp = 0, cyc = 0;
    logic [31:0] last_ts = 0;
    logic [7:0]  lfsr = 8'h5A;

    always #2.5 clk = ~clk;

    cmd_ring_proc dut (
        .clk(clk), .rst_n(rst_n), .kick(kick), .ring_base(64'(RB)), .wptr(wptr),
        .rptr(rptr), .busy(busy), .err(err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_wide(mem_req_wide), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_grid_x(gx), .disp_grid_y(gy),
        .disp_grid_z(gz), .disp_prog_addr(paddr), .disp_args_addr(aaddr)
    );

    // Memory model with pseudo-random back-pressure; reads answer one cycle later.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_req_ready <= lfsr[0] | lfsr[1];
        disp_ready    <= lfsr[2];
        mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_we;
        mem_rsp_data  <= mem[mem_req_addr[8:2]];
    end

    // Monitor: compare accepted writes, fetch addresses and dispatches against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mon_checks++;
                if (wi >= exp_wr.size()) begin
                    mon_fails++;
                    $display("FAIL R10 unexpected write addr=%h data=%h expected none", mem_req_addr, mem_req_wdata);
                end else if (exp_wr[wi].is_ts) begin
                    if (mem_req_addr != exp_wr[wi].addr || mem_req_wide || mem_req_wdata[31:0] <= last_ts
                        || mem_req_wdata[31:0] > cyc) begin
                        mon_fails++;
                        $display("FAIL %s ts write addr=%h wide=%b data=%h expected addr=%h narrow data in (%h,%h]",
                                 exp_wr[wi].tag, mem_req_addr, mem_req_wide, mem_req_wdata, exp_wr[wi].addr, last_ts, cyc);
                    end
                    last_ts = mem_req_wdata[31:0];
                    wi++;
                end else begin
                    if (mem_req_addr != exp_wr[wi].addr || mem_req_wdata != exp_wr[wi].data ||
                        mem_req_wide != exp_wr[wi].wide) begin
                        mon_fails++;
                        $display("FAIL %s write addr=%h data=%h wide=%b expected addr=%h data=%h wide=%b",
                                 exp_wr[wi].tag, mem_req_addr, mem_req_wdata, mem_req_wide,
                                 exp_wr[wi].addr, exp_wr[wi].data, exp_wr[wi].wide);
                    end
                    wi++;
                end
            end else if (mem_req_addr >= 64'(RB) && mem_req_addr < 64'(RB + 4*RING)) begin
                mon_checks++;
                if (mem_req_addr != 64'(RB + 4*(rptr % RING))) begin
                    mon_fails++;
                    $display("FAIL R2 fetch addr=%h expected %h", mem_req_addr, RB + 4*(rptr % RING));
                end
            end
        end
        if (rst_n && disp_valid && disp_ready) begin
            mon_checks++;
            if (di >= exp_dp.size()) begin
                mon_fails++;
                $display("FAIL R10 unexpected dispatch prog=%h expected none", paddr);
            end else begin
                if (gx != exp_dp[di].x || gy != exp_dp[di].y || gz != exp_dp[di].z ||
                    paddr != exp_dp[di].prog || aaddr != exp_dp[di].args) begin
                    mon_fails++;
                    $display("FAIL R5 dispatch grid=%h/%h/%h prog=%h args=%h expected %h/%h/%h %h %h",
                             gx, gy, gz, paddr, aaddr, exp_dp[di].x, exp_dp[di].y, exp_dp[di].z,
                             exp_dp[di].prog, exp_dp[di].args);
                end
                di++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic put(input logic [31:0] w);
        mem[RB/4 + (wp % RING)] = w;
        wp++;
    endtask

    function automatic logic [31:0] hdr(input logic [7:0] op, input int n);
        return {2'b11, 14'(n), op, 8'h00};
    endfunction

    task automatic run();
        wptr = 32'(wp);
        @(negedge clk) kick = 1;
        @(negedge clk) kick = 0;
        for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; wp = 0; wptr = 0;
        @(negedge clk);
    endtask

    task automatic rel(input logic [31:0] evt, input logic [2:0] sel, input logic [63:0] a, input logic [63:0] v);
        put(hdr(8'h49, 6)); put(evt); put({sel, 29'd0});
        put(a[31:0]); put(a[63:32]); put(v[31:0]); put(v[63:32]); put(32'h0);
    endtask

    task automatic wt(input logic [31:0] info, input logic [31:0] ref_v);
        put(hdr(8'h3C, 5)); put(info); put(32'(POLL_A)); put(32'h0);
        put(ref_v); put(32'hFFFF_FFFF); put(32'h10);
    endtask

    task automatic push_wr(input logic [63:0] a, input logic [63:0] d, input logic w, input logic ts, input string t);
        wr_item_t it;
        it.addr = a; it.data = d; it.wide = w; it.is_ts = ts; it.tag = t;
        exp_wr.push_back(it);
    endtask

    task automatic push_dp(input logic [31:0] x, y, z, input logic [63:0] p, a);
        dp_item_t it;
        it.x = x; it.y = y; it.z = z; it.prog = p; it.args = a;
        exp_dp.push_back(it);
    endtask

    initial begin
        int hp;
        for (int i = 0; i < 128; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(rptr == 0 && !err && !busy && !mem_req_valid && !disp_valid, "R1 reset", {rptr, 29'd0, err, busy, mem_req_valid}, 0);

        // R4 R5: registers via two writes, then a dispatch
        put(hdr(8'h76, 2)); put(32'd12); put(32'h0012_3456); put(32'h1);
        put(hdr(8'h76, 2)); put(32'd32); put(32'hB000_0000); put(32'hA);
        push_dp(32'd5, 32'd6, 32'd7, 64'h0000_0100_1234_5600, 64'h0000_000A_B000_0000);
        put(hdr(8'h15, 3)); put(32'd5); put(32'd6); put(32'd7); put(32'h1);
        run();
        chk(rptr == 32'(wp) && !busy, "R2 drained after dispatch", rptr, wp);
        chk(di == 1, "R5 dispatch seen", di, 1);

        // R4 index wrap modulo NREGS: start 76 -> 12
        put(hdr(8'h76, 2)); put(32'd76); put(32'hFF); put(32'h2);
        push_dp(32'd1, 32'd1, 32'd2, 64'h0000_0200_0000_FF00, 64'h0000_000A_B000_0000);
        put(hdr(8'h15, 3)); put(32'd1); put(32'd1); put(32'd2); put(32'h0);
        run();
        chk(di == 2, "R4 wrapped register write dispatch", di, 2);

        // R6 release selects 2 and 1
        push_wr(64'h180, 64'hDEAD_BEEF_0BAD_F00D, 1, 0, "R6");
        rel(32'h0, 3'd2, 64'h180, 64'hDEAD_BEEF_0BAD_F00D);
        push_wr(64'h1_0000_0190, 64'h1234_5678_9ABC_DEF0, 1, 0, "R6");
        rel(32'h5, 3'd1, 64'h1_0000_0190, 64'h1234_5678_9ABC_DEF0);
        run();
        chk(wi == 2, "R6 both releases written", wi, 2);

        // R7 timestamps, two in a row must increase
        push_wr(64'h1A0, 0, 0, 1, "R7");
        rel(32'h14, 3'd3, 64'h1A0, 64'h0);
        push_wr(64'h1A4, 0, 0, 1, "R7");
        rel(32'h14, 3'd3, 64'h1A4, 64'h0);
        run();
        chk(wi == 4, "R7 timestamps written", wi, 4);

        // R10 skip-only packets
        put(hdr(8'h58, 6)); for (int i = 0; i < 7; i++) put(32'hFFFF_FFFF);
        put(hdr(8'h46, 0)); put(32'h1234);
        run();
        chk(rptr == 32'(wp) && wi == 4 && di == 2, "R10 skip consumes only", rptr, wp);

        // R8 space 0 passes, space 1 geq passes
        mem[POLL_A/4] = 32'h50;
        wt(32'h03, 32'h99);
        wt(32'h15, 32'h40);
        run();
        chk(rptr == 32'(wp) && !err, "R8 waits pass", rptr, wp);

        // R9 failing equal wait rewinds and blocks the following release
        mem[POLL_A/4] = 32'h11;
        hp = wp;
        wt(32'h13, 32'h77);
        rel(32'h0, 3'd2, 64'h1B0, 64'h77);
        run();
        chk(rptr == 32'(hp) && !busy && !err, "R9 rewind to header", rptr, hp);
        chk(wi == 4, "R9 no release while blocked", wi, 4);
        run();
        chk(rptr == 32'(hp), "R9 retry still fails", rptr, hp);
        mem[POLL_A/4] = 32'h77;
        push_wr(64'h1B0, 64'h77, 1, 0, "R9");
        run();
        chk(rptr == 32'(wp) && wi == 5, "R9 retry passes after update", rptr, wp);

        // R8 greater-or-equal failing with smaller value
        mem[POLL_A/4] = 32'h3F;
        hp = wp;
        wt(32'h15, 32'h40);
        run();
        chk(rptr == 32'(hp), "R8 geq fails below ref", rptr, hp);
        mem[POLL_A/4] = 32'h40;
        run();
        chk(rptr == 32'(wp), "R8 geq passes at equal", rptr, wp);

        // R2 no work when rptr == wptr
        run();
        chk(rptr == 32'(wp) && !busy, "R2 idle with empty ring", rptr, wp);

        // R3 R11 bad packet type
        do_reset();
        chk(rptr == 0 && !err, "R1 after reset", rptr, 0);
        put(32'h4000_7600);
        put(hdr(8'h46, 0)); put(32'h0);
        run();
        chk(err && !busy && rptr == 1, "R3 bad type sets err", {err, rptr}, 1);
        run();
        chk(err && rptr == 1, "R11 kick ignored while halted", rptr, 1);

        // R11 unknown opcode
        do_reset();
        put(hdr(8'h99, 0)); put(32'h0);
        run();
        chk(err && rptr == 1, "R11 unknown opcode", {err, rptr}, 1);

        // R11 wrong count for wait
        do_reset();
        put(hdr(8'h3C, 4)); for (int i = 0; i < 5; i++) put(32'h0);
        run();
        chk(err && rptr == 1, "R11 wrong count", {err, rptr}, 1);

        // R11 unsupported release select and wait function
        do_reset();
        rel(32'h0, 3'd4, 64'h1C0, 64'h1);
        run();
        chk(err && rptr == 8, "R11 bad release select", {err, rptr}, 8);
        do_reset();
        wt(32'h10, 32'h0);
        run();
        chk(err && rptr == 7, "R11 bad wait function", {err, rptr}, 7);

        repeat (5) @(negedge clk);
        chk(wi == exp_wr.size() && di == exp_dp.size(), "R12 all expected traffic seen", wi, exp_wr.size());
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end
endmodule